// File: doc/BRIEF.md
# Multi-Lane Comma Deskew and Word Packer

This block joins two or more received character lanes into one wider word stream. Each lane supplies 10-bit characters that have already been recovered from the line, together with a valid strobe and a K-control flag. The block spots comma characters, holds each lane in a small elastic queue, and starts reading all lanes in the same cycle once every lane has a comma waiting at its head. This removes the skew between lanes.

After alignment the lanes are read in lockstep. Each lane packs four consecutive characters into a 40-bit word. The character received first sits in the lowest ten bits, and each of the four character positions carries its own comma flag and K flag. A comma always starts a new word. When commas stop arriving on all lanes together, a miss counter runs. On the fourth consecutive miss the block drops its aligned status, empties the queues and searches for alignment again.

Top module: `lane_bond_deskew`

## Requirements
- R1: After reset `aligned` and `out_valid` are low, and no word is emitted until alignment has been reached.
- R2: A character is a comma when its bits [6:0] (bit 0 is received first) equal 7'b1111100 or 7'b0000011. It is flagged in `out_comma`, and the comma test uses no other bits.
- R3: While not aligned, a lane discards every character at its queue head that is not a comma. `aligned` rises one cycle after every lane holds a comma at its head, and stays low while any lane lacks one.
- R4: Lanes whose commas arrive up to 4 characters apart produce words in which all lanes' commas share the same position. The first lockstep read takes the comma from every lane.
- R5: Lane l's word occupies `out_word[l*40 +: 40]`, with the character of position s (s=0 received first) in bits `[l*40+s*10 +: 10]`. Its comma flag is `out_comma[l*4+s]` and its K flag is `out_k[l*4+s]`.
- R6: A lockstep read that carries a comma restarts packing at position 0. An unfinished word is dropped, and no emitted word has a comma in positions 1 to 3.
- R7: A lockstep read with a comma on some lanes but not all is a miss. A read with commas on all lanes clears the miss count. The fourth consecutive miss clears `aligned` on the next edge and empties every lane queue.
- R8: After such a loss, the block aligns again on fresh commas and resumes correct words.
- R9: Each lane queue holds 8 entries and is never read while empty. A skew of 4 characters loses no character, and `out_valid` is only high while `aligned` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_LANES | Per-lane character strobe |
| in_char | input | NUM_LANES*10 | Per-lane character, lane l in bits [l*10 +: 10] |
| in_k | input | NUM_LANES | Per-lane K-control flag for the character |
| out_valid | output | 1 | One-cycle strobe for a packed multi-lane word |
| out_word | output | NUM_LANES*40 | Packed characters, four per lane |
| out_comma | output | NUM_LANES*4 | Comma flag per lane and position |
| out_k | output | NUM_LANES*4 | K flag per lane and position |
| aligned | output | 1 | Lanes are deskewed and read in lockstep |

## Verification
Several properties are checked by assertions on every cycle. No queue is popped while empty and no count exceeds the depth. No word leaves without alignment, and no emitted word holds a comma past its first position. A loss of alignment always follows three earlier misses and leaves every queue empty. The bench scenarios cover the rest: the actual removal of skew and of leading junk, the bit order and flag placement in packed words, dropping of partial words, the reset of the miss count by a matched comma, and recovery after a flush.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int CHAR_W = 10;
  localparam int SLOTS  = 4;

  typedef struct packed {
    logic              k;
    logic              comma;
    logic [CHAR_W-1:0] ch;
  } lane_ent_t;

  localparam int ENT_W = $bits(lane_ent_t);

  // seven-bit sync pattern in either polarity, bit 0 first on the line
  function automatic logic is_comma(input logic [CHAR_W-1:0] c);
    return (c[6:0] == 7'b1111100) || (c[6:0] == 7'b0000011);
  endfunction
endpackage

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign push  = wr_en && !full && !flush;
  assign pop   = rd_en && !empty && !flush;
  assign head  = mem[rp];

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/dsk_align_ctrl.sv
module dsk_align_ctrl #(
  parameter int NUM_LANES  = 2,
  parameter int SLOTS      = 4,
  parameter int FAIL_LIMIT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_LANES-1:0]     nonempty,
  input  logic [NUM_LANES-1:0]     head_comma,
  output logic [NUM_LANES-1:0]     pop,
  output logic                     rd_all,
  output logic [$clog2(SLOTS)-1:0] slot_idx,
  output logic                     emit,
  output logic                     flush,
  output logic                     aligned
);
  localparam int SW = $clog2(SLOTS);
  localparam int FW = $clog2(FAIL_LIMIT + 1);

  logic          aligned_q;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] fail_cnt;
  logic          all_ne, all_c, any_c, mismatch;

  assign all_ne   = &nonempty;
  assign all_c    = &head_comma;
  assign any_c    = |head_comma;
  assign rd_all   = aligned_q && all_ne;
  assign slot_idx = any_c ? '0 : slot_q;
  assign mismatch = rd_all && any_c && !all_c;
  assign flush    = mismatch && (fail_cnt == FW'(FAIL_LIMIT - 1));
  assign emit     = rd_all && (slot_idx == SW'(SLOTS - 1)) && !flush;
  assign aligned  = aligned_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pop
    // hunting: drop non-comma heads; locked: common read
    assign pop[g] = aligned_q ? rd_all : (nonempty[g] && !head_comma[g]);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      aligned_q <= 1'b0;
      slot_q    <= '0;
      fail_cnt  <= '0;
    end else if (!aligned_q) begin
      slot_q   <= '0;
      fail_cnt <= '0;
      if (all_ne && all_c) aligned_q <= 1'b1;
    end else if (rd_all) begin
      slot_q <= (slot_idx == SW'(SLOTS - 1)) ? '0 : slot_idx + 1'b1;
      if (mismatch)   fail_cnt <= fail_cnt + 1'b1;
      else if (any_c) fail_cnt <= '0;
    end
  end

  assert_fail_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fail_cnt < FW'(FAIL_LIMIT));
  assert_drop_after_misses_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(aligned_q) |-> ($past(fail_cnt) == FW'(FAIL_LIMIT - 1)) && $past(mismatch));
  assert_lock_on_commas_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned_q) |-> $past(all_c) && $past(all_ne));
endmodule

// File: rtl/dsk_word_pack.sv
module dsk_word_pack #(
  parameter int CHAR_W = 10,
  parameter int SLOTS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     load,
  input  logic [$clog2(SLOTS)-1:0] slot_idx,
  input  logic [CHAR_W-1:0]        ent_ch,
  input  logic                     ent_k,
  input  logic                     ent_comma,
  input  logic                     emit,
  output logic [SLOTS*CHAR_W-1:0]  word,
  output logic [SLOTS-1:0]         commas,
  output logic [SLOTS-1:0]         ks
);
  localparam int SW = $clog2(SLOTS);

  logic [SLOTS*CHAR_W-1:0] chars_q, chars_n;
  logic [SLOTS-1:0]        com_q, com_n, k_q, k_n;

  always_comb begin
    chars_n = chars_q;
    com_n   = com_q;
    k_n     = k_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (load && (slot_idx == SW'(s))) begin
        chars_n[s*CHAR_W +: CHAR_W] = ent_ch;
        com_n[s] = ent_comma;
        k_n[s]   = ent_k;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chars_q <= '0;
      com_q   <= '0;
      k_q     <= '0;
    end else if (load) begin
      chars_q <= chars_n;
      com_q   <= com_n;
      k_q     <= k_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      commas <= '0;
      ks     <= '0;
    end else if (emit) begin
      word   <= chars_n;
      commas <= com_n;
      ks     <= k_n;
    end
  end
endmodule

// File: rtl/lane_bond_deskew.sv
module lane_bond_deskew #(
  parameter int NUM_LANES  = 2,
  parameter int FIFO_DEPTH = 8,
  parameter int FAIL_LIMIT = 4
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic [NUM_LANES-1:0]                         in_valid,
  input  logic [NUM_LANES*dsk_pkg::CHAR_W-1:0]         in_char,
  input  logic [NUM_LANES-1:0]                         in_k,
  output logic                                         out_valid,
  output logic [NUM_LANES*dsk_pkg::SLOTS*dsk_pkg::CHAR_W-1:0] out_word,
  output logic [NUM_LANES*dsk_pkg::SLOTS-1:0]          out_comma,
  output logic [NUM_LANES*dsk_pkg::SLOTS-1:0]          out_k,
  output logic                                         aligned
);
  import dsk_pkg::*;
  localparam int SW    = $clog2(SLOTS);
  localparam int WORD_W = SLOTS * CHAR_W;

  logic [NUM_LANES-1:0] nonempty, head_comma, pop, fifo_empty;
  logic                 rd_all, emit, flush;
  logic [SW-1:0]        slot_idx;
  lane_ent_t            heads [NUM_LANES];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lane_ent_t wr_ent;
    logic [ENT_W-1:0] head_raw;
    logic full_unused;

    assign wr_ent.ch    = in_char[l*CHAR_W +: CHAR_W];
    assign wr_ent.k     = in_k[l];
    assign wr_ent.comma = is_comma(in_char[l*CHAR_W +: CHAR_W]);

    dsk_lane_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .wr_en   (in_valid[l]),
      .wr_data (wr_ent),
      .rd_en   (pop[l]),
      .head    (head_raw),
      .empty   (fifo_empty[l]),
      .full    (full_unused)
    );

    assign heads[l]      = lane_ent_t'(head_raw);
    assign nonempty[l]   = !fifo_empty[l];
    assign head_comma[l] = nonempty[l] && heads[l].comma;

    dsk_word_pack #(.CHAR_W(CHAR_W), .SLOTS(SLOTS)) pack_i (
      .clk       (clk),
      .rst       (rst),
      .clr       (flush),
      .load      (rd_all),
      .slot_idx  (slot_idx),
      .ent_ch    (heads[l].ch),
      .ent_k     (heads[l].k),
      .ent_comma (heads[l].comma),
      .emit      (emit),
      .word      (out_word[l*WORD_W +: WORD_W]),
      .commas    (out_comma[l*SLOTS +: SLOTS]),
      .ks        (out_k[l*SLOTS +: SLOTS])
    );
  end

  dsk_align_ctrl #(.NUM_LANES(NUM_LANES), .SLOTS(SLOTS), .FAIL_LIMIT(FAIL_LIMIT)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .nonempty   (nonempty),
    .head_comma (head_comma),
    .pop        (pop),
    .rd_all     (rd_all),
    .slot_idx   (slot_idx),
    .emit       (emit),
    .flush      (flush),
    .aligned    (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= emit;
  end

  assert_valid_needs_lock_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> aligned);
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(aligned) |-> &fifo_empty);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    assert_comma_first_slot_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_comma[l*SLOTS+1 +: SLOTS-1] == '0));
  end
endmodule

// File: tb/lane_bond_deskew_tb_top.sv
module lane_bond_deskew_tb_top;
  localparam int NL = 2;
  localparam int EW = NL*48;
  localparam logic [9:0] COMMA_A = 10'h17C;  // bits[6:0]=1111100
  localparam logic [9:0] COMMA_B = 10'h283;  // bits[6:0]=0000011

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NL-1:0]   in_valid = '0;
  logic [NL*10-1:0] in_char = '0;
  logic [NL-1:0]   in_k = '0;
  logic            out_valid;
  logic [NL*40-1:0] out_word;
  logic [NL*4-1:0] out_comma, out_k;
  logic            aligned;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [10:0] seq [NL][64];
  int          len [NL];
  int          skw [NL];
  logic [EW-1:0] got_q [$];
  logic [EW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  lane_bond_deskew #(.NUM_LANES(NL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char), .in_k(in_k),
    .out_valid(out_valid), .out_word(out_word), .out_comma(out_comma),
    .out_k(out_k), .aligned(aligned)
  );

  always @(negedge clk) if (!rst && out_valid) got_q.push_back({out_k, out_comma, out_word});

  function automatic logic [10:0] dch(input int l, input int i, input bit k);
    return {k, 2'(l), 6'(i), 2'b01};
  endfunction

  function automatic bit bench_comma(input logic [9:0] c);
    return (c == COMMA_A) || (c == COMMA_B);
  endfunction

  task automatic chk(input string rq, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    got_q.delete(); exp_q.delete();
    for (int l = 0; l < NL; l++) begin len[l] = 0; skw[l] = 0; end
  endtask

  task automatic feed();
    int total = 0;
    for (int l = 0; l < NL; l++) if (len[l] + skw[l] > total) total = len[l] + skw[l];
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        int i = t - skw[l];
        if (i >= 0 && i < len[l]) begin
          in_valid[l] = 1'b1;
          in_char[l*10 +: 10] = seq[l][i][9:0];
          in_k[l] = seq[l][i][10];
        end else begin
          in_valid[l] = 1'b0;
        end
      end
    end
    @(negedge clk);
    in_valid = '0;
    repeat (20) @(negedge clk);
  endtask

  // expected word from four characters per lane starting at st[l]
  task automatic exp_group(input int s0, input int s1);
    logic [EW-1:0] e = '0;
    int st [NL];
    st[0] = s0; st[1] = s1;
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < 4; s++) begin
        logic [10:0] c = seq[l][st[l] + s];
        e[l*40 + s*10 +: 10] = c[9:0];
        e[80 + l*4 + s]      = bench_comma(c[9:0]);
        e[88 + l*4 + s]      = c[10];
      end
    exp_q.push_back(e);
  endtask

  task automatic cmp_words(input string rq);
    chk({rq, " word count"}, EW'(got_q.size()), EW'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({rq, " word"}, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic put_group(input int l, input int base, input bit with_comma, input int tag);
    seq[l][base] = with_comma ? {1'b1, COMMA_A} : dch(l, tag, 1'b0);
    for (int s = 1; s < 4; s++) seq[l][base + s] = dch(l, tag + s, 1'b0);
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    chk("R1 aligned after reset", EW'(aligned), '0);
    chk("R1 out_valid after reset", EW'(out_valid), '0);
    repeat (5) @(negedge clk);
    chk("R1 no words before alignment", EW'(got_q.size()), '0);
  endtask

  // R2 R5: zero skew, both comma polarities, K flag on a data char
  task automatic t_pack();
    do_reset();
    for (int l = 0; l < NL; l++) begin
      put_group(l, 0, 1'b1, 0);
      put_group(l, 4, 1'b1, 4);
      len[l] = 8;
    end
    seq[1][4] = {1'b1, COMMA_B};
    seq[0][6] = dch(0, 6, 1'b1);
    seq[1][2] = dch(1, 2, 1'b1);
    exp_group(0, 0); exp_group(4, 4);
    feed();
    cmp_words("R5 R2 packing");
    chk("R3 aligned after commas", EW'(aligned), EW'(1));
  endtask

  // R4 R9: lane 1 four characters late
  task automatic t_skew();
    do_reset();
    for (int l = 0; l < NL; l++) begin
      put_group(l, 0, 1'b1, 10);
      put_group(l, 4, 1'b0, 20);
      put_group(l, 8, 1'b1, 30);
      len[l] = 12;
    end
    skw[1] = 4;
    exp_group(0, 0); exp_group(4, 4); exp_group(8, 8);
    feed();
    cmp_words("R4 R9 skew of 4");
  endtask

  // R3: leading junk dropped, lock waits for every lane
  task automatic t_hunt();
    do_reset();
    seq[0][0] = {1'b1, COMMA_A}; seq[0][1] = dch(0, 1, 1'b0); len[0] = 2;
    for (int i = 0; i < 4; i++) seq[1][i] = dch(1, 40 + i, 1'b0);
    len[1] = 4;
    feed();
    chk("R3 no lock with one lane lacking comma", EW'(aligned), '0);
    do_reset();
    seq[0][0] = dch(0, 50, 1'b0); seq[0][1] = dch(0, 51, 1'b1);
    put_group(0, 2, 1'b1, 52); len[0] = 6;
    for (int i = 0; i < 5; i++) seq[1][i] = dch(1, 60 + i, 1'b0);
    put_group(1, 5, 1'b1, 5); len[1] = 9;
    exp_group(2, 5);
    feed();
    cmp_words("R3 junk discarded");
    chk("R3 aligned", EW'(aligned), EW'(1));
  endtask

  // R6: comma mid-word restarts packing
  task automatic t_restart();
    do_reset();
    for (int l = 0; l < NL; l++) begin
      seq[l][0] = {1'b1, COMMA_A};
      seq[l][1] = dch(l, 1, 1'b0);
      seq[l][2] = dch(l, 2, 1'b0);
      put_group(l, 3, 1'b1, 3);
      len[l] = 7;
    end
    exp_group(3, 3);
    feed();
    cmp_words("R6 partial word dropped");
  endtask

  task automatic load_phase(input int groups, input bit lane1_comma);
    for (int g = 0; g < groups; g++) begin
      put_group(0, g*4, 1'b1, g*4);
      put_group(1, g*4, lane1_comma, g*4);
    end
    len[0] = groups*4; len[1] = groups*4; skw[0] = 0; skw[1] = 0;
  endtask

  // R7 R8: miss counting, loss, flush and relock
  task automatic t_miss();
    do_reset();
    load_phase(1, 1'b1); feed();
    chk("R7 locked at start", EW'(aligned), EW'(1));
    load_phase(3, 1'b0); feed();
    chk("R7 three misses keep lock", EW'(aligned), EW'(1));
    load_phase(1, 1'b1); feed();
    chk("R7 matched comma keeps lock", EW'(aligned), EW'(1));
    load_phase(3, 1'b0); feed();
    chk("R7 count cleared by match", EW'(aligned), EW'(1));
    load_phase(1, 1'b0); feed();
    chk("R7 fourth miss drops lock", EW'(aligned), '0);
    got_q.delete(); exp_q.delete();
    load_phase(2, 1'b1);
    seq[1][1] = dch(1, 77, 1'b1);
    exp_group(0, 0); exp_group(4, 4);
    feed();
    chk("R8 relocked", EW'(aligned), EW'(1));
    cmp_words("R8 words after relock");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pack();
    t_skew();
    t_hunt();
    t_restart();
    t_miss();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule